// File: doc/BRIEF.md
# SCSI Byte Parity Unit

This unit produces and checks the parity bit that travels with every byte on an 8-bit SCSI data path. On the transmit side it computes the parity bit for the byte being sent, in the same cycle. On the receive side it compares the arriving parity bit with the value it expects. When checking is switched on and the two differ, it sets a sticky error flag. It can also raise an interrupt request in that same cycle.

Software sets the behaviour through four controls:
- **Sense select.** Inverts the parity sense on both the transmit and receive sides.
- **Check enable.** Turns receive checking on or off. Generation is not affected.
- **Error action.** Chooses between only setting the flag and also raising an interrupt.
- **Inject.** A one-shot request that corrupts the parity of exactly one later outgoing byte, so that error-recovery code can be tested.

Phase sequencing and the bus handshake belong to the surrounding logic.

Top module: `scsi_byte_parity`

## Requirements
- R1: With sense select low and no injection armed, `tx_par` is chosen so that `tx_data` plus `tx_par` together hold an odd number of ones. This is odd parity over the 8 data bits.
- R2: With `cfg_invert_sense` high, the generated bit is the inverse of the R1 value. The receive check also expects the inverted value.
- R3: A one-cycle pulse on `inject_req` arms a one-shot. The first `tx_valid` cycle after the pulse carries an inverted `tx_par`, and the one-shot then clears, so later bytes are normal. A `tx_valid` in the same cycle as the `inject_req` pulse is not affected; the corruption goes to the next byte.
- R4: If `rx_valid` is high, `cfg_check_en` is high and `rx_par` differs from the expected bit, `parity_err` is high from the next clock edge.
- R5: With `cfg_check_en` low, no received byte sets `parity_err`, whatever its parity.
- R6: `parity_err` stays high until a cycle with `err_clr` high. If a new error is detected in that same cycle, the flag stays set.
- R7: With `cfg_irq_on_err` high, `irq_req` rises on the same edge as `parity_err` and clears with `err_clr`. With `cfg_irq_on_err` low, an error leaves `irq_req` low.
- R8: After reset, `parity_err` and `irq_req` are low and no injection is armed.
- R9: `tx_par` is combinational: it follows `tx_data` in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_invert_sense | input | 1 | 1 inverts the parity sense |
| cfg_check_en | input | 1 | 1 enables the receive parity check |
| cfg_irq_on_err | input | 1 | 1 raises an interrupt request together with the error flag |
| inject_req | input | 1 | Pulse that arms a one-shot bad-parity byte |
| err_clr | input | 1 | Write-1 clear of the error flag and interrupt |
| tx_valid | input | 1 | Outgoing byte present |
| tx_data | input | 8 | Outgoing byte |
| tx_par | output | 1 | Generated parity bit for `tx_data` |
| rx_valid | input | 1 | Incoming byte present |
| rx_data | input | 8 | Incoming byte |
| rx_par | input | 1 | Incoming parity bit |
| parity_err | output | 1 | Sticky parity error flag |
| irq_req | output | 1 | Interrupt request |

## Verification
The hardest situation to create is the one-shot injection meeting other traffic. Examples are an inject pulse in the same cycle as a transmitted byte, or several idle cycles between the pulse and the next byte. Directed sequences place the pulse right on, before and between `tx_valid` cycles. Random traffic then issues rare inject pulses while `tx_valid` toggles irregularly. Set-and-clear collisions on the error flag are produced the same way: an error byte and `err_clr` are driven in one cycle, both by direct sequence and by chance in the random phase.

// File: rtl/scsi_byte_parity.sv
module scsi_byte_parity #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_invert_sense,
  input  logic         cfg_check_en,
  input  logic         cfg_irq_on_err,
  input  logic         inject_req,
  input  logic         err_clr,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  output logic         tx_par,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  input  logic         rx_par,
  output logic         parity_err,
  output logic         irq_req
);

  logic inject_armed;
  logic rx_expect;
  logic rx_bad;

  assign tx_par    = ~(^tx_data) ^ cfg_invert_sense ^ inject_armed;
  assign rx_expect = ~(^rx_data) ^ cfg_invert_sense;
  assign rx_bad    = rx_valid & cfg_check_en & (rx_par ^ rx_expect);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inject_armed <= 1'b0;
      parity_err   <= 1'b0;
      irq_req      <= 1'b0;
    end else begin
      inject_armed <= inject_req | (inject_armed & ~tx_valid);
      parity_err   <= rx_bad | (parity_err & ~err_clr);
      irq_req      <= (rx_bad & cfg_irq_on_err) | (irq_req & ~err_clr);
    end
  end

endmodule

module scsi_byte_parity_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_invert_sense,
  input logic         cfg_check_en,
  input logic         cfg_irq_on_err,
  input logic         inject_req,
  input logic         err_clr,
  input logic         tx_valid,
  input logic [W-1:0] tx_data,
  input logic         tx_par,
  input logic         rx_valid,
  input logic [W-1:0] rx_data,
  input logic         rx_par,
  input logic         parity_err,
  input logic         irq_req,
  input logic         armed
);

  assert_odd_total_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !cfg_invert_sense && !armed) |-> ((^{tx_data, tx_par}) == 1'b1));

  assert_one_shot_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && tx_valid && !inject_req) |=> !armed);

  assert_no_set_when_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_check_en && !parity_err) |=> !parity_err);

  assert_err_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(parity_err) |-> $past(rx_valid && cfg_check_en));

  assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !rx_valid) |=> !parity_err);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (parity_err && !err_clr) |=> parity_err);

  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> parity_err);

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_irq_on_err && !irq_req) |=> !irq_req);

endmodule

bind scsi_byte_parity scsi_byte_parity_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cfg_invert_sense(cfg_invert_sense), .cfg_check_en(cfg_check_en),
  .cfg_irq_on_err(cfg_irq_on_err), .inject_req(inject_req), .err_clr(err_clr),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_par(tx_par),
  .rx_valid(rx_valid), .rx_data(rx_data), .rx_par(rx_par),
  .parity_err(parity_err), .irq_req(irq_req), .armed(inject_armed)
);

// File: tb/scsi_byte_parity_test.sv
`timescale 1ns/1ps
module scsi_byte_parity_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inv = 1'b0, chk = 1'b0, irqen = 1'b0, inj = 1'b0, clr = 1'b0;
  logic txv = 1'b0, rxv = 1'b0, rxp = 1'b0;
  logic [7:0] txd = '0, rxd = '0;
  logic txp, perr, irq;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  logic m_armed = 1'b0, m_err = 1'b0, m_irq = 1'b0;

  always #2 clk = ~clk;

  scsi_byte_parity #(.W(8)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_invert_sense(inv), .cfg_check_en(chk),
    .cfg_irq_on_err(irqen), .inject_req(inj), .err_clr(clr),
    .tx_valid(txv), .tx_data(txd), .tx_par(txp),
    .rx_valid(rxv), .rx_data(rxd), .rx_par(rxp),
    .parity_err(perr), .irq_req(irq)
  );

  function automatic logic odd_bit(input logic [7:0] d, input logic s);
    return ~(^d) ^ s;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    logic bad;
    #1;
    if (txv) check(m_armed ? "R3" : (inv ? "R2" : "R1"), txp, odd_bit(txd, inv) ^ m_armed);
    @(posedge clk);
    bad = rxv & chk & (rxp ^ odd_bit(rxd, inv));
    m_armed = inj | (m_armed & ~txv);
    m_err = bad | (m_err & ~clr);
    m_irq = (bad & irqen) | (m_irq & ~clr);
    @(negedge clk);
    check(chk ? "R4" : "R5", perr, m_err);
    check("R7", irq, m_irq);
    inj = 0; clr = 0; txv = 0; rxv = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    check("R8", perr, 1'b0);
    check("R8", irq, 1'b0);
    rst_n = 1;
    @(negedge clk);
    txv = 1; txd = 8'h00; step();
    check("R8", txp, 1'b1);
    // R9: tx_par follows data in the same cycle
    txd = 8'h01; #1; check("R9", txp, 1'b0);
    txd = 8'h03; #1; check("R9", txp, 1'b1);
    // R1 / R2
    txv = 1; txd = 8'hA5; step();
    inv = 1; txv = 1; txd = 8'hA4; step();
    inv = 0;
    // R3: inject then idle, then two bytes
    inj = 1; step();
    step();
    txv = 1; txd = 8'h3C; step();
    txv = 1; txd = 8'h3C; step();
    // R3: inject with tx_valid in the same cycle
    inj = 1; txv = 1; txd = 8'h11; step();
    txv = 1; txd = 8'h11; step();
    txv = 1; txd = 8'h11; step();
    // R5: check disabled
    chk = 0; rxv = 1; rxd = 8'h0F; rxp = 1'b0; step();
    check("R5", perr, 1'b0);
    // R4/R7: flag with irq off
    chk = 1; irqen = 0; rxv = 1; rxd = 8'h0F; rxp = 1'b0; step();
    check("R4", perr, 1'b1);
    check("R7", irq, 1'b0);
    step(); check("R6", perr, 1'b1);
    clr = 1; step(); check("R6", perr, 1'b0);
    // R7 irq on, R6 set-wins-over-clear
    irqen = 1; rxv = 1; rxd = 8'hFF; rxp = 1'b0; step();
    check("R7", irq, 1'b1);
    clr = 1; rxv = 1; rxd = 8'hFF; rxp = 1'b0; step();
    check("R6", perr, 1'b1);
    clr = 1; step();
    check("R6", perr, 1'b0);
    check("R7", irq, 1'b0);
    // R2 on receive: inverted sense, correct byte accepted
    inv = 1; rxv = 1; rxd = 8'hFF; rxp = 1'b0; step();
    check("R2", perr, 1'b0);
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 15) == 0) inv = $urandom_range(0, 1);
      if ($urandom_range(0, 15) == 0) chk = $urandom_range(0, 1);
      if ($urandom_range(0, 15) == 0) irqen = $urandom_range(0, 1);
      inj = ($urandom_range(0, 11) == 0);
      clr = ($urandom_range(0, 7) == 0);
      txv = $urandom_range(0, 1);
      txd = 8'($urandom);
      rxv = $urandom_range(0, 1);
      rxd = 8'($urandom);
      rxp = odd_bit(rxd, inv) ^ ($urandom_range(0, 3) == 0);
      step();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule